// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept or dropped, judging only its 6-byte destination address. The address arrives one byte per cycle from the receive path, first byte first. The block compares the address against a table of up to sixteen programmable 48-bit station addresses. Each entry can be switched on or off by its own bit. It also classifies the address as unicast, multicast or broadcast, and a command register can accept each class without any table match.

Software programs the table, the per-entry enables and the command word through a simple word-write port. The match can be turned off entirely or inverted, which turns the table into a reject list. A frame is judged with the settings that were in force when its first address byte arrived. Writes made while a frame is being judged apply from the following frame on. The verdict is a one-cycle pulse on the cycle after the sixth address byte.

Top module: `mac_addr_filter`

## Requirements
- R1: After reset `decision_valid_o` and `accept_o` are 0. All entries are disabled and the command word is 0, so every frame is rejected until software programs the block.
- R2: Entry n has its high word at byte offset 8n and its low word at 8n+4. The high word carries address byte 0 in bits 31:24, byte 1 in 23:16, byte 2 in 15:8 and byte 3 in 7:0. The low word carries byte 4 in bits 31:24 and byte 5 in 23:16. Low-word bits 15:0 are ignored.
- R3: The enable word at offset 0x80 has bit n enabling entry n. A disabled entry never matches, even when its stored address equals the incoming one.
- R4: The command word at offset 0x84 uses these bits: bit 0 accepts every unicast frame, bit 1 every multicast frame, bit 2 every broadcast frame, bit 3 inverts the table result, and bit 4 enables table comparison. Bits 31:5 are ignored.
- R5: An address of all ones is broadcast. An address whose byte 0 has bit 0 set and which is not all ones is multicast. Every other address is unicast.
- R6: A frame is accepted when table comparison is enabled and (any enabled entry matches) XOR (invert bit) is 1, or when the accept bit for its address class is set. Otherwise it is rejected.
- R7: Address bytes are sampled when `byte_valid_i` is 1, and the first is marked by `sof_i`. Idle cycles between bytes are allowed. `decision_valid_o` is 1 for exactly the one cycle after the sixth byte is sampled. `accept_o` carries the verdict in that cycle and is 0 in all other cycles.
- R8: All table, enable and command values are captured in the cycle the `sof_i` byte is sampled. A write in that same cycle or later in the frame affects only later frames.
- R9: A `sof_i` byte arriving before the sixth byte restarts the address with that byte. Bytes sampled without a preceding `sof_i`, and bytes after the sixth, are ignored and produce no verdict.
- R10: Writes with bits 1:0 of the offset non-zero, or to offsets above 0x84, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| byte_valid_i | input | 1 | Address byte present this cycle |
| sof_i | input | 1 | Marks the first address byte of a frame |
| byte_i | input | 8 | Destination address byte |
| decision_valid_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | Frame accepted (valid with strobe) |

## Verification
Addresses are chosen so that each test has one cause for its outcome. One pattern is an exact match. Others differ from a stored entry only in the first or only in the last byte, which shows that the comparison covers both ends of the 48-bit field. Multicast and broadcast addresses are run against each class-accept bit in turn, which separates the two classes, since broadcast also has the group bit set. Writes timed in the same cycle as a frame's first byte and in the middle of a frame show that the settings are taken at frame start. Restarted, headless, gapped and over-long byte streams show that the verdict strobe depends only on the sixth byte after a start marker.

// File: rtl/maf_pkg.sv
package maf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * 8;

  typedef logic [ADDR_W-1:0] mac_addr_t;

  typedef struct packed {
    logic cam_en;
    logic invert;
    logic acc_bcast;
    logic acc_mcast;
    logic acc_ucast;
  } filt_cmd_t;

  typedef enum logic [1:0] {KIND_UCAST, KIND_MCAST, KIND_BCAST} addr_kind_t;

  function automatic addr_kind_t classify(mac_addr_t a);
    if (&a)              return KIND_BCAST;
    if (a[ADDR_W-8])     return KIND_MCAST;
    return KIND_UCAST;
  endfunction
endpackage

// File: rtl/maf_regs.sv
module maf_regs
  import maf_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int AW        = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [AW-1:0]                    addr_i,
  input  logic [31:0]                      wdata_i,
  input  logic                             snap_i,
  output logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_o,
  output logic [N_ENTRIES-1:0]             en_o,
  output filt_cmd_t                        cmd_o
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam logic [AW-1:0] EN_ADDR  = AW'(N_ENTRIES * 8);
  localparam logic [AW-1:0] CMD_ADDR = AW'(N_ENTRIES * 8 + 4);
  localparam int CMD_W = $bits(filt_cmd_t);

  logic             word_ok, in_ent, is_hi;
  logic [IDX_W-1:0] idx;

  assign word_ok = we_i && (addr_i[1:0] == 2'b00);
  assign in_ent  = addr_i < EN_ADDR;
  assign is_hi   = !addr_i[2];
  assign idx     = addr_i[IDX_W+2:3];

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic [31:0] hi_q;
    logic [15:0] lo_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (word_ok && in_ent && idx == IDX_W'(i)) begin
        if (is_hi) hi_q <= wdata_i;
        else       lo_q <= wdata_i[31:16];
      end
    end
    // frame-start snapshot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent_o[i] <= '0;
      else if (snap_i) ent_o[i] <= {hi_q, lo_q};
    end
  end

  logic [N_ENTRIES-1:0] en_q;
  filt_cmd_t            cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cmd_q <= '0;
    end else if (word_ok) begin
      if (addr_i == EN_ADDR)  en_q  <= wdata_i[N_ENTRIES-1:0];
      if (addr_i == CMD_ADDR) cmd_q <= filt_cmd_t'(wdata_i[CMD_W-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      cmd_o <= '0;
    end else if (snap_i) begin
      en_o  <= en_q;
      cmd_o <= cmd_q;
    end
  end
endmodule

// File: rtl/maf_capture.sv
module maf_capture
  import maf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  logic      sof_i,
  input  logic [7:0] byte_i,
  output logic      start_o,
  output logic      last_o,
  output mac_addr_t addr_o
);
  localparam int CNT_W = $clog2(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  logic [ADDR_BYTES-2:0][7:0] buf_q;
  logic [CNT_W-1:0]           cnt_q;
  logic                       busy_q;

  assign start_o = valid_i && sof_i;
  assign last_o  = valid_i && !sof_i && busy_q && (cnt_q == LAST_IDX);

  for (genvar k = 0; k < ADDR_BYTES - 1; k++) begin : g_byte
    assign addr_o[ADDR_W-1-8*k -: 8] = buf_q[k];
  end
  assign addr_o[7:0] = byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_o) begin
      buf_q[0] <= byte_i;
      cnt_q    <= CNT_W'(1);
      busy_q   <= 1'b1;
    end else if (valid_i && busy_q) begin
      if (last_o) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        buf_q[cnt_q] <= byte_i;
        cnt_q        <= cnt_q + CNT_W'(1);
      end
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0 && cnt_q <= LAST_IDX));
endmodule

// File: rtl/maf_cam.sv
module maf_cam
  import maf_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic [N_ENTRIES-1:0][ADDR_W-1:0] ent_i,
  input  logic [N_ENTRIES-1:0]             en_i,
  input  mac_addr_t                        addr_i,
  output logic [N_ENTRIES-1:0]             hit_o
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    assign hit_o[i] = en_i[i] && (ent_i[i] == addr_i);
  end
endmodule

// File: rtl/mac_addr_filter.sv
module mac_addr_filter
  import maf_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int REG_AW    = $clog2(N_ENTRIES * 8 + 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              byte_valid_i,
  input  logic              sof_i,
  input  logic [7:0]        byte_i,
  output logic              decision_valid_o,
  output logic              accept_o
);
  logic                             start, last;
  mac_addr_t                        addr_full;
  logic [N_ENTRIES-1:0][ADDR_W-1:0] snap_ent;
  logic [N_ENTRIES-1:0]             snap_en, hits;
  filt_cmd_t                        snap_cmd;

  maf_capture u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (byte_valid_i),
    .sof_i   (sof_i),
    .byte_i  (byte_i),
    .start_o (start),
    .last_o  (last),
    .addr_o  (addr_full)
  );

  maf_regs #(.N_ENTRIES(N_ENTRIES), .AW(REG_AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .snap_i  (start),
    .ent_o   (snap_ent),
    .en_o    (snap_en),
    .cmd_o   (snap_cmd)
  );

  maf_cam #(.N_ENTRIES(N_ENTRIES)) u_cam (
    .ent_i  (snap_ent),
    .en_i   (snap_en),
    .addr_i (addr_full),
    .hit_o  (hits)
  );

  addr_kind_t kind;
  logic       type_ok, cam_ok, verdict;

  always_comb begin
    kind = classify(addr_full);
    unique case (kind)
      KIND_BCAST: type_ok = snap_cmd.acc_bcast;
      KIND_MCAST: type_ok = snap_cmd.acc_mcast;
      default:    type_ok = snap_cmd.acc_ucast;
    endcase
    cam_ok  = snap_cmd.cam_en && ((|hits) ^ snap_cmd.invert);
    verdict = type_ok || cam_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
    end else begin
      decision_valid_o <= last;
      accept_o         <= last && verdict;
    end
  end

  p_valid_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |=> !decision_valid_o);
  p_valid_after_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decision_valid_o |-> $past(byte_valid_i));
  p_no_hit_all_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_en == '0) |-> (hits == '0));
  p_cmd_zero_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && snap_cmd == '0) |=> (decision_valid_o && !accept_o));
  p_bcast_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && snap_cmd.acc_bcast && (&addr_full)) |=> accept_o);
endmodule

// File: tb/mac_addr_filter_test.sv
module mac_addr_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] a = '0;
  logic [31:0]   d = '0;
  logic          bv = 1'b0, sf = 1'b0;
  logic [7:0]    bb = '0;
  logic          dv, acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_addr_filter #(.N_ENTRIES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(a),
    .reg_wdata_i(d), .byte_valid_i(bv), .sof_i(sf), .byte_i(bb),
    .decision_valid_o(dv), .accept_o(acc)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [31:0] live_hi [N];
  logic [15:0] live_lo [N];
  logic [31:0] live_en, live_cmd;
  logic [47:0] snap_ent [N];
  logic [31:0] snap_en, snap_cmd;
  logic [7:0]  mb [6];
  int          got;
  bit          act, exp_v, exp_a;

  function automatic bit decide();
    logic [47:0] ad;
    bit bc, mc, uc, hit;
    ad  = {mb[0], mb[1], mb[2], mb[3], mb[4], mb[5]};
    bc  = (ad == 48'hFFFF_FFFF_FFFF);
    mc  = mb[0][0] && !bc;
    uc  = !mb[0][0];
    hit = 0;
    for (int i = 0; i < N; i++)
      if (snap_en[i] && snap_ent[i] == ad) hit = 1;
    return (snap_cmd[4] && (hit ^ snap_cmd[3])) ||
           (uc && snap_cmd[0]) || (mc && snap_cmd[1]) || (bc && snap_cmd[2]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        live_hi[i] = '0; live_lo[i] = '0; snap_ent[i] = '0;
      end
      live_en = '0; live_cmd = '0; snap_en = '0; snap_cmd = '0;
      got = 0; act = 0; exp_v = 0; exp_a = 0;
    end else begin
      exp_v = 0; exp_a = 0;
      if (bv) begin
        if (sf) begin
          for (int i = 0; i < N; i++) snap_ent[i] = {live_hi[i], live_lo[i]};
          snap_en = live_en; snap_cmd = live_cmd;
          mb[0] = bb; got = 1; act = 1;
        end else if (act) begin
          mb[got] = bb; got++;
          if (got == 6) begin exp_v = 1; exp_a = decide(); act = 0; end
        end
      end
      if (we && a[1:0] == 2'b00) begin
        if (a < 8'h80) begin
          if (a[2]) live_lo[a[6:3]] = d[31:16];
          else      live_hi[a[6:3]] = d;
        end else if (a == 8'h80) live_en = {16'h0, d[15:0]};
        else if (a == 8'h84) live_cmd = {27'h0, d[4:0]};
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (dv !== exp_v || acc !== exp_a) begin
        fails++;
        $display("FAIL %s: valid=%0b accept=%0b expected valid=%0b accept=%0b",
                 cur_req, dv, acc, exp_v, exp_a);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  task automatic cyc(input bit w, input logic [7:0] ad, input logic [31:0] dt,
                     input bit v, input bit s, input logic [7:0] b);
    @(negedge clk);
    we = w; a = ad; d = dt; bv = v; sf = s; bb = b;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr(input logic [7:0] ad, input logic [31:0] dt);
    cyc(1, ad, dt, 0, 0, 0);
  endtask
  task automatic frame(input logic [47:0] m);
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 1, k == 0, m[47-8*k -: 8]);
    idle(2);
  endtask
  task automatic set_entry(input int i, input logic [47:0] m);
    wr(8'(8*i), m[47:16]);
    wr(8'(8*i+4), {m[15:0], 16'hABCD});
  endtask

  localparam logic [47:0] MA = 48'h0211_2233_4455;
  localparam logic [47:0] MB = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] MC = 48'h0100_5E00_0001;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    checks++;
    if (dv !== 1'b0 || acc !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset valid=%0b accept=%0b expected 0 0", dv, acc);
    end
    rst_n = 1'b1;
    idle(2);
    frame(MA); frame(BC); frame(MC);

    cur_req = "R2";
    set_entry(3, MA); wr(8'h80, 32'h8); wr(8'h84, 32'h10);
    frame(MA);
    frame(MA ^ 48'h1);
    frame(MA ^ 48'h0400_0000_0000);
    set_entry(0, MB); set_entry(15, MC); wr(8'h80, 32'h8009);
    frame(MB); frame(MC);

    cur_req = "R3";
    wr(8'h80, 32'h0001);
    frame(MA); frame(MC); frame(MB);
    wr(8'h80, 32'h0);
    frame(MB);

    cur_req = "R4";
    wr(8'h84, 32'h1);
    frame(MA); frame(MC); frame(BC);
    wr(8'h84, 32'hFFFF_FFE0);
    frame(MA); frame(BC);

    cur_req = "R5";
    wr(8'h84, 32'h2);
    frame(MC); frame(BC); frame(MA);
    wr(8'h84, 32'h4);
    frame(BC); frame(MC); frame(48'hFFFF_FFFF_FFFE);

    cur_req = "R6";
    wr(8'h80, 32'h8); wr(8'h84, 32'h18);
    frame(MA); frame(MB);
    wr(8'h84, 32'h08);
    frame(MA); frame(MB);
    wr(8'h84, 32'h12);
    frame(MC); frame(MA);

    cur_req = "R8";
    wr(8'h84, 32'h10);
    cyc(0, 0, 0, 1, 1, MA[47:40]);
    cyc(0, 0, 0, 1, 0, MA[39:32]);
    cyc(1, 8'h80, 32'h0, 1, 0, MA[31:24]);
    cyc(1, 8'h84, 32'h0, 1, 0, MA[23:16]);
    cyc(0, 0, 0, 1, 0, MA[15:8]);
    cyc(0, 0, 0, 1, 0, MA[7:0]);
    idle(2);
    frame(MA);
    wr(8'h84, 32'h10);
    cyc(1, 8'h80, 32'h8, 1, 1, MA[47:40]);
    for (int k = 1; k < 6; k++) cyc(0, 0, 0, 1, 0, MA[47-8*k -: 8]);
    idle(2);
    frame(MA);

    cur_req = "R7";
    for (int k = 0; k < 6; k++) begin
      cyc(0, 0, 0, 1, k == 0, MA[47-8*k -: 8]);
      idle(k);
    end
    idle(2);

    cur_req = "R9";
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, k == 0, MB[47-8*k -: 8]);
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 1, k == 0, MA[47-8*k -: 8]);
    idle(2);
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 1, 0, MA[47-8*k -: 8]);
    idle(2);
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 1, k == 0, MA[47-8*k -: 8]);
    for (int k = 0; k < 7; k++) cyc(0, 0, 0, 1, 0, MA[47-8*(k%6) -: 8]);
    idle(2);

    cur_req = "R10";
    wr(8'h01, 32'h1234_5678);
    wr(8'h1A, 32'h0);
    wr(8'h82, 32'h0);
    wr(8'h86, 32'h0);
    wr(8'h88, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    frame(MA); frame(MB); frame(MC); frame(BC);

    idle(3);
    report();
  end
endmodule